// File: doc/BRIEF.md
# Power Supervisor Fault Sequencer

This block is the digital supervisor of a multi-output power controller. Its inputs are comparator results that are already synchronized to the clock: flags that show each input supply is above its threshold, an over-voltage flag on the switching output, an over-current event line, one under-voltage flag per output, and a flag that shows the soft-start ramp has finished. It steps from a held-off reset state, through soft-start, into normal running. It drives the soft-start enable, one enable per converter, a power-good output and a fault output.

Faults go into a sticky latch. An over-voltage on the switching output sets the latch on the next edge. Over-current sets it only on the third event. Under-voltage on the linear outputs is masked until soft-start finishes, and then trips the latch only after a run of consecutive low samples. While the latch is set, every converter and the soft-start are held off. Only losing one of the input supplies and getting it back clears the latch, because that passes the block through reset again.

Top module: `pwr_supervisor`

## Requirements
- R1: Leaving reset needs all supply flags (`supply_ok`, one bit per supply) high together, in any order. `ss_en` and every `conv_en` bit rise on the second clock edge after the last flag goes high, and not on the first.
- R2: `ss_en` stays low until reset is left. After that it stays high, with or without `ss_done`, as long as no fault is latched.
- R3: `ov_sw` sampled high on an edge outside reset sets `fault` on that same edge, with no filtering.
- R4: The latch is set by the third rising edge of `oc_evt`, not by the first or second. A level held high counts once. The count saturates at three.
- R5: Under-voltage flags on the linear outputs (`uv_flag` bits 1 and above) have no effect until the edge after `ss_done` is first sampled high. From then on, one flag high for UV_HOLD consecutive sampled edges sets the latch on the last of those edges. A shorter run does not.
- R6: `uv_flag` bit 0 (the switching output) never sets the latch. It only affects power-good.
- R7: On the edge that sets `fault`, all `conv_en` bits, `ss_en` and `pgood` go low. They stay low while `fault` is high.
- R8: `fault` stays high until a supply flag drops. After the drop, `fault` is still high following the first edge and low following the second. The over-current count is cleared too.
- R9: `pgood` is high one edge after all `uv_flag` bits are sampled low, and only outside reset and with no fault latched. Any high `uv_flag` bit clears it on the next edge.
- R10: If a supply flag drops while running, the enables fall on the second edge after the drop. The start-up of R1 begins again when all supplies return.
- R11: The synchronous reset `rst` drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | NSUP | Per-supply above-threshold flags |
| ov_sw | input | 1 | Over-voltage on the switching output |
| oc_evt | input | 1 | Over-current event line; rising edges are counted |
| uv_flag | input | NOUT | Under-voltage flags; bit 0 is the switching output, the rest are linear outputs |
| ss_done | input | 1 | Soft-start ramp has finished |
| conv_en | output | NOUT | Converter enables |
| ss_en | output | 1 | Soft-start enable |
| pgood | output | 1 | Power-good |
| fault | output | 1 | Sticky fault latch |

## Verification
Two pairs of functions can fall on the same edge. The first pair is the over-voltage trip and the third over-current edge. The second is a fault trip and the loss of a supply, which clears the latch. The bench raises `ov_sw` on the same cycle as the third `oc_evt` pulse and expects a single clean latch one edge later. It also raises `ov_sw` on the same cycle that a supply flag drops, and expects `fault` to go high after the first edge and low after the second. Every supply pattern, every supply ordering, every under-voltage run length around UV_HOLD and every over-current count from one to five are swept, and each expected value is worked out from the edge counts above.

// File: rtl/pwr_sup_pkg.sv
`timescale 1ns/1ps
package pwr_sup_pkg;
  typedef enum logic [1:0] {
    PS_RESET = 2'd0,
    PS_SOFT  = 2'd1,
    PS_RUN   = 2'd2
  } psup_state_e;
endpackage

// File: rtl/sup_por_sync.sv
`timescale 1ns/1ps
// Registers the AND of all supply flags; one edge of latency.
module sup_por_sync #(
  parameter int NSUP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSUP-1:0] supply_ok,
  output logic            por_ok
);
  always_ff @(posedge clk) begin
    if (rst) por_ok <= 1'b0;
    else     por_ok <= &supply_ok;
  end
endmodule

// File: rtl/sup_oc_count.sv
`timescale 1ns/1ps
// Counts rising edges of the over-current line, saturating at TRIP.
module sup_oc_count #(
  parameter int TRIP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt,
  output logic trip
);
  localparam int CW = $clog2(TRIP + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP - 1);
  localparam logic [CW-1:0] TOP  = CW'(TRIP);

  logic          evt_q;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = evt & ~evt_q;
  assign trip = rise & ~clr & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      cnt   <= '0;
    end else begin
      evt_q <= evt;
      if (clr)                     cnt <= '0;
      else if (rise && cnt != TOP) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_uv_filter.sv
`timescale 1ns/1ps
// Requires HOLD consecutive high samples while armed before tripping.
module sup_uv_filter #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic uv,
  output logic trip
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  assign trip = arm & uv & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!arm || !uv)   cnt <= '0;
    else if (cnt != LAST)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_supervisor.sv
`timescale 1ns/1ps
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int NSUP    = 3,
  parameter int NOUT    = 3,
  parameter int OC_TRIP = 3,
  parameter int UV_HOLD = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSUP-1:0] supply_ok,
  input  logic            ov_sw,
  input  logic            oc_evt,
  input  logic [NOUT-1:0] uv_flag,
  input  logic            ss_done,
  output logic [NOUT-1:0] conv_en,
  output logic            ss_en,
  output logic            pgood,
  output logic            fault
);
  psup_state_e     state, state_d;
  logic            por_ok;
  logic            active;
  logic            oc_trip;
  logic [NOUT-1:0] uv_trip;
  logic            fault_d;
  logic            on_d;

  sup_por_sync #(.NSUP(NSUP)) u_por (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .por_ok(por_ok)
  );

  assign active = (state != PS_RESET);

  sup_oc_count #(.TRIP(OC_TRIP)) u_oc (
    .clk(clk), .rst(rst), .clr(!active || !por_ok), .evt(oc_evt), .trip(oc_trip)
  );

  // Switching output under-voltage is reported on power-good only.
  assign uv_trip[0] = 1'b0;
  for (genvar g = 1; g < NOUT; g++) begin : g_lin
    sup_uv_filter #(.HOLD(UV_HOLD)) u_uv (
      .clk(clk), .rst(rst),
      .arm(por_ok && state == PS_RUN),
      .uv(uv_flag[g]), .trip(uv_trip[g])
    );
  end

  always_comb begin
    state_d = state;
    if (!por_ok) begin
      state_d = PS_RESET;
    end else begin
      case (state)
        PS_RESET: state_d = PS_SOFT;
        PS_SOFT:  state_d = ss_done ? PS_RUN : PS_SOFT;
        PS_RUN:   state_d = PS_RUN;
        default:  state_d = PS_RESET;
      endcase
    end
  end

  always_comb begin
    if (!por_ok)                                      fault_d = 1'b0;
    else if (active && (ov_sw || oc_trip || |uv_trip)) fault_d = 1'b1;
    else                                              fault_d = fault;
  end

  assign on_d = (state_d != PS_RESET) && !fault_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_RESET;
      fault   <= 1'b0;
      ss_en   <= 1'b0;
      conv_en <= '0;
      pgood   <= 1'b0;
    end else begin
      state   <= state_d;
      fault   <= fault_d;
      ss_en   <= on_d;
      conv_en <= {NOUT{on_d}};
      pgood   <= on_d && (uv_flag == '0);
    end
  end
endmodule

// File: rtl/pwr_supervisor_chk.sv
`timescale 1ns/1ps
module pwr_supervisor_chk #(
  parameter int NSUP = 3,
  parameter int NOUT = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NSUP-1:0] supply_ok,
  input logic            ov_sw,
  input logic [NOUT-1:0] uv_flag,
  input logic [NOUT-1:0] conv_en,
  input logic            ss_en,
  input logic            pgood,
  input logic            fault
);
  AST_FAULT_GATES_ALL: assert property (@(posedge clk) disable iff (rst)
    fault |-> (conv_en == '0 && !ss_en && !pgood)); // R7

  AST_OV_TRIPS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (ov_sw && conv_en != '0) |=> (fault || !$past(&supply_ok, 2))); // R3

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault && (&supply_ok) && $past(&supply_ok)) |=> fault); // R8

  AST_SUPPLY_LOSS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !(&supply_ok) |=> ##1 (conv_en == '0 && !ss_en && !fault)); // R10

  AST_SS_AFTER_POR: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_en) |-> $past(&supply_ok, 2)); // R1

  AST_PGOOD_NO_UV: assert property (@(posedge clk) disable iff (rst)
    pgood |-> ($past(uv_flag) == '0)); // R9
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.NSUP(NSUP), .NOUT(NOUT)) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .ov_sw(ov_sw),
  .uv_flag(uv_flag), .conv_en(conv_en), .ss_en(ss_en),
  .pgood(pgood), .fault(fault)
);

// File: tb/sim_pwr_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_supervisor;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] supply_ok;
  logic       ov_sw, oc_evt, ss_done;
  logic [2:0] uv_flag;
  logic [2:0] conv_en;
  logic       ss_en, pgood, fault;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_supervisor #(.NSUP(3), .NOUT(3), .OC_TRIP(3), .UV_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ov_sw(ov_sw), .oc_evt(oc_evt),
    .uv_flag(uv_flag), .ss_done(ss_done), .conv_en(conv_en), .ss_en(ss_en),
    .pgood(pgood), .fault(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic power_cycle();
    ov_sw = 0; oc_evt = 0; uv_flag = 0; ss_done = 0;
    supply_ok = 3'b000;
    tick(3);
    supply_ok = 3'b111;
    tick(2);
  endtask

  task automatic go_run();
    ss_done = 1;
    tick(1);
  endtask

  task automatic oc_pulse();
    oc_evt = 1; tick(1);
    oc_evt = 0; tick(1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; supply_ok = 3'b111; ov_sw = 0; oc_evt = 0; uv_flag = 0; ss_done = 0;
    @(negedge clk);
    tick(3);
    // R11: reset holds every output low
    chk("R11", "conv_en in reset", conv_en, 0);
    chk("R11", "ss_en in reset", ss_en, 0);
    chk("R11", "pgood in reset", pgood, 0);
    chk("R11", "fault in reset", fault, 0);
    rst = 0; supply_ok = 0;
    tick(2);

    // R1: every supply pattern
    for (int pat = 0; pat < 8; pat++) begin
      supply_ok = pat[2:0];
      tick(3);
      chk("R1", $sformatf("ss_en pat %0d", pat), ss_en, (pat == 7) ? 1 : 0);
      chk("R1", $sformatf("conv_en pat %0d", pat), conv_en, (pat == 7) ? 7 : 0);
      supply_ok = 0;
      tick(2);
    end

    // R1: every arrival order, second-edge timing
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        if (b != a) begin
          supply_ok = 0; tick(2);
          supply_ok = 3'b001 << a; tick(3);
          chk("R1", "one supply only", ss_en, 0);
          supply_ok = supply_ok | (3'b001 << b); tick(3);
          chk("R1", "two supplies only", ss_en, 0);
          supply_ok = 3'b111; tick(1);
          chk("R1", "first edge after last supply", ss_en, 0);
          tick(1);
          chk("R1", "second edge after last supply", ss_en, 1);
        end
      end
    end

    // R2: soft-start enable holds with or without ss_done
    power_cycle();
    tick(20);
    chk("R2", "ss_en without ss_done", ss_en, 1);
    // R9 sweep in soft-start, R5 masked
    for (int pat = 0; pat < 8; pat++) begin
      uv_flag = pat[2:0];
      tick(1);
      chk("R9", $sformatf("pgood uv %0d", pat), pgood, (pat == 0) ? 1 : 0);
    end
    uv_flag = 3'b110; tick(3 * HOLD);
    chk("R5", "linear uv masked before ss_done", fault, 0);
    uv_flag = 0;
    go_run();
    tick(2);
    chk("R2", "ss_en after ss_done", ss_en, 1);
    chk("R9", "pgood running clean", pgood, 1);

    // R5: run-length sweep on each linear output
    for (int o = 1; o < 3; o++) begin
      for (int len = 1; len <= HOLD + 2; len++) begin
        power_cycle(); go_run();
        uv_flag = 3'b001 << o;
        tick(len);
        uv_flag = 0;
        chk("R5", $sformatf("out %0d len %0d", o, len), fault, (len >= HOLD) ? 1 : 0);
        chk("R7", $sformatf("conv_en out %0d len %0d", o, len), conv_en, (len >= HOLD) ? 0 : 7);
      end
    end

    // R6: switching-output under-voltage never latches
    power_cycle(); go_run();
    uv_flag = 3'b001; tick(3 * HOLD);
    chk("R6", "fault from bit0 uv", fault, 0);
    chk("R9", "pgood during bit0 uv", pgood, 0);
    uv_flag = 0; tick(1);
    chk("R9", "pgood after bit0 uv clears", pgood, 1);

    // R3/R7/R8: over-voltage, stickiness, clearing
    ov_sw = 1; tick(1);
    chk("R3", "fault after ov", fault, 1);
    chk("R7", "conv_en in fault", conv_en, 0);
    chk("R7", "ss_en in fault", ss_en, 0);
    chk("R7", "pgood in fault", pgood, 0);
    ov_sw = 0; tick(10);
    chk("R8", "fault sticky", fault, 1);
    supply_ok = 3'b101; tick(1);
    chk("R8", "fault one edge after drop", fault, 1);
    tick(1);
    chk("R8", "fault two edges after drop", fault, 0);
    supply_ok = 3'b111; tick(2);
    chk("R10", "restart after clear", ss_en, 1);

    // R4: event-count sweep
    for (int n = 1; n <= 5; n++) begin
      power_cycle(); go_run();
      for (int k = 0; k < n; k++) oc_pulse();
      chk("R4", $sformatf("fault after %0d oc", n), fault, (n >= 3) ? 1 : 0);
    end
    // R4: held level counts once
    power_cycle(); go_run();
    oc_evt = 1; tick(10); oc_evt = 0; tick(1);
    chk("R4", "held oc counts once", fault, 0);
    oc_pulse();
    chk("R4", "second oc edge", fault, 0);
    oc_pulse();
    chk("R4", "third oc edge", fault, 1);

    // R8: counter cleared by supply cycle
    power_cycle(); go_run();
    oc_pulse(); oc_pulse();
    power_cycle(); go_run();
    oc_pulse(); oc_pulse();
    chk("R8", "oc count cleared by supply loss", fault, 0);

    // Coincidence: ov with third oc edge
    power_cycle(); go_run();
    oc_pulse(); oc_pulse();
    oc_evt = 1; ov_sw = 1; tick(1);
    chk("R3", "ov with third oc", fault, 1);
    chk("R4", "conv_en with ov and oc", conv_en, 0);
    oc_evt = 0; ov_sw = 0;

    // Coincidence: ov with supply loss
    power_cycle(); go_run();
    ov_sw = 1; supply_ok = 3'b011; tick(1);
    chk("R3", "ov latched before loss applies", fault, 1);
    ov_sw = 0; tick(1);
    chk("R8", "loss clears latch", fault, 0);
    chk("R10", "conv_en off after loss", conv_en, 0);

    // R10: drop while running
    power_cycle(); go_run();
    supply_ok = 3'b110; tick(1);
    chk("R10", "conv_en first edge after drop", conv_en, 7);
    tick(1);
    chk("R10", "conv_en second edge after drop", conv_en, 0);
    supply_ok = 3'b111; tick(2);
    chk("R10", "conv_en after return", conv_en, 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule